// File: doc/BRIEF.md
# SDIO Read-Wait Transfer Pauser

This block sits beside the data engine of an SD host controller and lets software halt a multi-block read without abandoning it. When a pause is requested, the block waits until the current block has ended. It then holds the card's DAT[2] line low so the card stops sending data, and it raises a freeze signal that holds the transfer's byte and block counters. The SD clock is never gated. The command line stays free, so the host can issue commands such as a single-register I/O access while the read is parked.

When software asks to continue, the block waits until no command is outstanding. It then drives DAT[2] high for exactly one cycle, lets the line float, and drops the freeze. The byte and block counters pick up from the values they held. A small command tracker reports when a new command may start: no command may be outstanding, and a fixed number of clocks must have passed since the last response.

Top module: `sdio_readwait`

## Requirements
- R1: A pause request that arrives during a read (`xfer_active`=1) sets `rw_pending`. The pause begins only on a cycle where `blk_end`=1: `rw_active` goes high one clock after that cycle. A request made in the same cycle as `blk_end` takes effect at that boundary.
- R2: While `rw_active`=1, the block drives DAT[2] low: `dat2_oe`=1 and `dat2_o`=0.
- R3: While `freeze`=1, `byte_cnt` and `blk_cnt` hold their values, even when `data_tick` or `blk_end` pulses. A `blk_end` that starts a pause still counts: it increments `blk_cnt` and clears `byte_cnt`.
- R4: After release, `data_tick` again increments `byte_cnt`, and `blk_end` again increments `blk_cnt`, starting from the values held during the pause.
- R5: An accepted resume puts the block into a release phase for exactly one cycle (`dat2_oe`=1, `dat2_o`=1). After that, `dat2_oe`=0 and `freeze`=0.
- R6: `cmd_busy` is set by `cmd_start` and cleared by `cmd_done`. A resume is accepted only on a cycle where `cmd_busy` is 0. A resume requested while a command is outstanding is held, and the release phase begins two clocks after the cycle carrying `cmd_done`.
- R7: `cmd_ready` is 1 only when `cmd_busy` is 0 and at least GAP_CYC (default 8) clocks have passed since the last `cmd_done`. If `cmd_done` is sampled at edge E, `cmd_ready` is 0 after E+7 and 1 after E+8.
- R8: When `xfer_active`=0, a pause request is ignored: `rw_pending` stays 0, and a following `blk_end` does not start a pause.
- R9: A pause request during a pause is discarded, so the next boundary after release does not pause. A resume request while running is discarded.
- R10: After reset: `dat2_oe`=0, `freeze`=0, `rw_active`=0, `rw_pending`=0, `cmd_busy`=0, `cmd_ready`=1, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_active | input | 1 | A multi-block read is in progress |
| data_tick | input | 1 | One data byte received |
| blk_end | input | 1 | End bit of the current block seen |
| rw_req | input | 1 | Software request to pause the read |
| resume_req | input | 1 | Software request to continue the read |
| cmd_start | input | 1 | A command has been launched on CMD |
| cmd_done | input | 1 | The response to the outstanding command has finished |
| dat2_o | output | 1 | Value driven onto DAT[2] |
| dat2_oe | output | 1 | Output enable for DAT[2] |
| freeze | output | 1 | Hold the transfer state in the data engine |
| rw_active | output | 1 | DAT[2] is held low for a pause |
| rw_pending | output | 1 | Pause requested, waiting for a block boundary |
| cmd_busy | output | 1 | A command is outstanding |
| cmd_ready | output | 1 | A new command may be launched |
| byte_cnt | output | BYTE_W | Bytes received in the current block |
| blk_cnt | output | BLK_W | Blocks completed |

## Verification
The bench sweeps the position of the pause request across every byte of a short block, including the cycle that carries the block end itself. This shows whether requests are correctly held to the boundary and whether the counters freeze at the right values. Each position is run twice: once with a plain resume, and once with a command outstanding during the resume. This separates immediate release from release deferred until `cmd_done`. Further patterns cover requests with no read in progress, stray requests in the wrong state, and the command spacing counted edge by edge.

// File: rtl/sdrw_pkg.sv
package sdrw_pkg;

    typedef enum logic [1:0] {
        RW_RUN  = 2'd0,
        RW_HOLD = 2'd1,
        RW_REL  = 2'd2
    } rw_state_e;

    typedef struct packed {
        logic dat;
        logic oe;
        logic frz;
    } line_drive_t;

    function automatic line_drive_t drive_of(rw_state_e s);
        line_drive_t d;
        d.dat = (s == RW_REL);
        d.oe  = (s != RW_RUN);
        d.frz = (s != RW_RUN);
        return d;
    endfunction

endpackage

// File: rtl/sdrw_ctrl.sv
module sdrw_ctrl
    import sdrw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      xfer_active,
    input  logic      blk_end,
    input  logic      rw_req,
    input  logic      resume_req,
    input  logic      cmd_busy,
    output rw_state_e state,
    output logic      pend
);
    rw_state_e state_q, state_d;
    logic pend_q, pend_d, rpend_q, rpend_d;
    logic go, accept;

    assign go     = (state_q == RW_RUN) && xfer_active && (pend_q || rw_req) && blk_end;
    assign accept = (state_q == RW_HOLD) && (rpend_q || resume_req) && !cmd_busy;

    always_comb begin
        state_d = state_q;
        case (state_q)
            RW_RUN:  if (go) state_d = RW_HOLD;
            RW_HOLD: if (accept) state_d = RW_REL;
            RW_REL:  state_d = RW_RUN;
            default: state_d = RW_RUN;
        endcase
    end

    always_comb begin
        if ((state_q != RW_RUN) || !xfer_active || go) pend_d = 1'b0;
        else                                           pend_d = pend_q | rw_req;
        if ((state_q != RW_HOLD) || accept) rpend_d = 1'b0;
        else                                rpend_d = rpend_q | resume_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RW_RUN;
            pend_q  <= 1'b0;
            rpend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            rpend_q <= rpend_d;
        end
    end

    assign state = state_q;
    assign pend  = pend_q;
endmodule

// File: rtl/sdrw_xfer_cnt.sv
module sdrw_xfer_cnt #(
    parameter int BYTE_W = 10,
    parameter int BLK_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze,
    input  logic              data_tick,
    input  logic              blk_end,
    output logic [BYTE_W-1:0] byte_cnt,
    output logic [BLK_W-1:0]  blk_cnt
);
    logic [BYTE_W-1:0] byte_q;
    logic [BLK_W-1:0]  blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            blk_q  <= '0;
        end else if (!freeze) begin
            if (blk_end) begin
                blk_q  <= blk_q + 1'b1;
                byte_q <= '0;
            end else if (data_tick) begin
                byte_q <= byte_q + 1'b1;
            end
        end
    end

    assign byte_cnt = byte_q;
    assign blk_cnt  = blk_q;
endmodule

// File: rtl/sdrw_cmd_track.sv
module sdrw_cmd_track #(
    parameter int GAP_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_start,
    input  logic cmd_done,
    output logic busy,
    output logic ready
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_CYC);

    logic             busy_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            gap_q  <= GAP_MAX;
        end else begin
            if (cmd_start)     busy_q <= 1'b1;
            else if (cmd_done) busy_q <= 1'b0;
            if (cmd_done)             gap_q <= '0;
            else if (gap_q < GAP_MAX) gap_q <= gap_q + 1'b1;
        end
    end

    assign busy  = busy_q;
    assign ready = !busy_q && (gap_q >= GAP_MAX);
endmodule

// File: rtl/sdio_readwait.sv
module sdio_readwait
    import sdrw_pkg::*;
#(
    parameter int BYTE_W  = 10,
    parameter int BLK_W   = 9,
    parameter int GAP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_active,
    input  logic              data_tick,
    input  logic              blk_end,
    input  logic              rw_req,
    input  logic              resume_req,
    input  logic              cmd_start,
    input  logic              cmd_done,
    output logic              dat2_o,
    output logic              dat2_oe,
    output logic              freeze,
    output logic              rw_active,
    output logic              rw_pending,
    output logic              cmd_busy,
    output logic              cmd_ready,
    output logic [BYTE_W-1:0] byte_cnt,
    output logic [BLK_W-1:0]  blk_cnt
);
    rw_state_e   st;
    line_drive_t drv;
    logic        busy_w;

    sdrw_cmd_track #(.GAP_CYC(GAP_CYC)) u_cmd (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_done(cmd_done),
        .busy(busy_w), .ready(cmd_ready)
    );

    sdrw_ctrl u_ctrl (
        .clk(clk), .rst(rst), .xfer_active(xfer_active), .blk_end(blk_end),
        .rw_req(rw_req), .resume_req(resume_req), .cmd_busy(busy_w),
        .state(st), .pend(rw_pending)
    );

    assign drv = drive_of(st);

    sdrw_xfer_cnt #(.BYTE_W(BYTE_W), .BLK_W(BLK_W)) u_cnt (
        .clk(clk), .rst(rst), .freeze(drv.frz), .data_tick(data_tick),
        .blk_end(blk_end), .byte_cnt(byte_cnt), .blk_cnt(blk_cnt)
    );

    assign dat2_o    = drv.dat;
    assign dat2_oe   = drv.oe;
    assign freeze    = drv.frz;
    assign rw_active = (st == RW_HOLD);
    assign cmd_busy  = busy_w;
endmodule

// File: rtl/sdio_readwait_chk.sv
module sdio_readwait_chk #(
    parameter int BYTE_W = 10,
    parameter int BLK_W  = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              xfer_active,
    input logic              blk_end,
    input logic              cmd_busy,
    input logic              dat2_o,
    input logic              dat2_oe,
    input logic              freeze,
    input logic              rw_active,
    input logic              rw_pending,
    input logic [BYTE_W-1:0] byte_cnt,
    input logic [BLK_W-1:0]  blk_cnt
);
    a_r1_pause_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(rw_active) |-> $past(blk_end));

    a_r2_hold_drives_low: assert property (@(posedge clk) disable iff (rst)
        rw_active |-> (dat2_oe && !dat2_o));

    a_r3_counters_held: assert property (@(posedge clk) disable iff (rst)
        freeze |=> ($stable(byte_cnt) && $stable(blk_cnt)));

    a_r5_high_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (dat2_oe && dat2_o) |=> (!dat2_oe && !freeze));

    a_r6_resume_idle_cmd: assert property (@(posedge clk) disable iff (rst)
        $fell(rw_active) |-> !$past(cmd_busy));

    a_r8_no_read_no_pending: assert property (@(posedge clk) disable iff (rst)
        !xfer_active |=> !rw_pending);
endmodule

bind sdio_readwait sdio_readwait_chk #(.BYTE_W(BYTE_W), .BLK_W(BLK_W)) u_chk (
    .clk(clk), .rst(rst), .xfer_active(xfer_active), .blk_end(blk_end),
    .cmd_busy(cmd_busy), .dat2_o(dat2_o), .dat2_oe(dat2_oe), .freeze(freeze),
    .rw_active(rw_active), .rw_pending(rw_pending), .byte_cnt(byte_cnt),
    .blk_cnt(blk_cnt)
);

// File: tb/sdio_readwait_bench.sv
module sdio_readwait_bench;
    localparam int BYTE_W = 10;
    localparam int BLK_W  = 9;
    localparam int NB     = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xfer_active = 0, data_tick = 0, blk_end = 0, rw_req = 0, resume_req = 0;
    logic cmd_start = 0, cmd_done = 0;
    logic dat2_o, dat2_oe, freeze, rw_active, rw_pending, cmd_busy, cmd_ready;
    logic [BYTE_W-1:0] byte_cnt;
    logic [BLK_W-1:0]  blk_cnt;

    int n_chk = 0, n_bad = 0;
    int exp_byte = 0, exp_blk = 0;

    always #2 clk = ~clk;

    sdio_readwait u_sdio_readwait (
        .clk(clk), .rst(rst), .xfer_active(xfer_active), .data_tick(data_tick),
        .blk_end(blk_end), .rw_req(rw_req), .resume_req(resume_req),
        .cmd_start(cmd_start), .cmd_done(cmd_done), .dat2_o(dat2_o),
        .dat2_oe(dat2_oe), .freeze(freeze), .rw_active(rw_active),
        .rw_pending(rw_pending), .cmd_busy(cmd_busy), .cmd_ready(cmd_ready),
        .byte_cnt(byte_cnt), .blk_cnt(blk_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        data_tick = 0; blk_end = 0; rw_req = 0; resume_req = 0;
        cmd_start = 0; cmd_done = 0;
    endtask

    task automatic chk_cnt(input string tag);
        chk({tag, " byte_cnt"}, int'(byte_cnt), exp_byte);
        chk({tag, " blk_cnt"}, int'(blk_cnt), exp_blk);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst = 0;
        step();
        // R10 reset state
        chk("R10 dat2_oe", dat2_oe, 0);
        chk("R10 freeze", freeze, 0);
        chk("R10 rw_active", rw_active, 0);
        chk("R10 rw_pending", rw_pending, 0);
        chk("R10 cmd_busy", cmd_busy, 0);
        chk("R10 cmd_ready", cmd_ready, 1);
        chk_cnt("R10");

        // R8: no read in progress
        rw_req = 1; step();
        chk("R8 pending ignored", rw_pending, 0);
        blk_end = 1; step(); exp_blk++; exp_byte = 0;
        chk("R8 no pause", rw_active, 0);

        xfer_active = 1;
        for (int cmdc = 0; cmdc < 2; cmdc++) begin
            for (int k = 0; k <= NB; k++) begin
                // send NB data ticks, then block end; request placed at slot k
                for (int i = 0; i <= NB; i++) begin
                    if (i < NB) begin data_tick = 1; exp_byte++; end
                    else begin blk_end = 1; exp_blk++; exp_byte = 0; end
                    if (i == k) rw_req = 1;
                    step();
                    if (i >= k && i < NB)
                        chk("R1 held pending", rw_pending, 1);
                    if (i < NB)
                        chk("R1 no early pause", rw_active, 0);
                end
                chk("R1 pause at boundary", rw_active, 1);
                chk("R2 dat2_oe low", dat2_oe, 1);
                chk("R2 dat2_o low", dat2_o, 0);
                // R3 activity during pause is ignored
                for (int j = 0; j < 3; j++) begin
                    data_tick = 1; blk_end = (j == 1);
                    step();
                    chk_cnt("R3 frozen");
                end
                // R9 pause request while paused discarded
                rw_req = 1; step();
                if (cmdc == 1) begin
                    cmd_start = 1; step();
                    chk("R6 busy", cmd_busy, 1);
                    resume_req = 1; step();
                    for (int j = 0; j < 3; j++) begin
                        step();
                        chk("R6 deferred", rw_active, 1);
                    end
                    cmd_done = 1; step();
                    chk("R6 still held at done edge", rw_active, 1);
                    chk("R6 busy cleared", cmd_busy, 0);
                    step();
                end else begin
                    resume_req = 1; step();
                end
                chk("R5 release high", dat2_o, 1);
                chk("R5 release oe", dat2_oe, 1);
                chk("R5 release frozen", freeze, 1);
                step();
                chk("R5 floated", dat2_oe, 0);
                chk("R5 unfrozen", freeze, 0);
                // R4 counting resumes from held values
                data_tick = 1; step(); exp_byte++;
                data_tick = 1; step(); exp_byte++;
                chk_cnt("R4 resumed");
                // R9: discarded request does not pause at next boundary
                blk_end = 1; step(); exp_blk++; exp_byte = 0;
                chk("R9 stale request", rw_active, 0);
                chk_cnt("R4 block counted");
                // R9: stray resume while running
                resume_req = 1; step();
                chk("R9 stray resume", dat2_oe, 0);
            end
        end

        // R7 command spacing
        cmd_start = 1; step();
        chk("R7 busy not ready", cmd_ready, 0);
        cmd_done = 1; step();
        for (int e = 1; e <= 8; e++) begin
            step();
            chk("R7 gap", cmd_ready, (e >= 8) ? 1 : 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule